// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block sits beside a byte-wide asynchronous memory port, already synchronised to the system clock. It watches the access cycles on that port for one specific ordered run of six read addresses. Five fixed addresses form a shared unlock prefix. The sixth address picks one of four commands: save the array to nonvolatile storage, reload the array from nonvolatile storage, turn automatic save-on-power-loss off, or turn it back on. When the run completes, the block emits a single-cycle command pulse together with a 2-bit command code. A downstream store/recall engine consumes that pulse.

An access is the falling edge of the active-low chip select. When the option is enabled, a falling edge of the active-low output enable while chip select is held low also counts as an access. The access is a read when the active-low write enable is high at that edge. Any write, any stray read, or an unknown sixth address breaks the run. While the engine reports busy, accesses are not counted and the run starts over.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset, `cmd_vld` is low and no partial sequence is remembered.
- R2: The five reads 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, followed directly by a read of 0x8FC0, produce a pulse with `cmd_code` = 0 (store).
- R3: The same five-read prefix followed by 0x4C63 gives code 1 (recall), by 0x8B45 gives code 2 (automatic save off), and by 0x4B46 gives code 3 (automatic save on).
- R4: `cmd_vld` is high for exactly one clock. It rises in the clock after the edge that made the sixth access, and it is low after any access that does not complete a sequence.
- R5: Only `addr[15:0]` is compared. The value of `addr[16]` has no effect on matching.
- R6: An access made with `we_n` low aborts any partial sequence, and that access never counts as a step.
- R7: A read of an address other than the next expected one aborts the sequence. If that address is 0x4E38, it counts as step one of a new attempt.
- R8: A sixth read that matches none of the four command addresses produces no pulse and aborts the sequence. If that read is 0x4E38, it starts a new attempt.
- R9: An access is a falling edge of `ce_n`. With `OE_CLOCKS` = 1, a falling edge of `oe_n` while `ce_n` is low is also an access. A falling edge of `oe_n` while `ce_n` is high is not an access.
- R10: While `busy` is high, accesses are ignored, no pulse is emitted, and any partial sequence is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Store/recall engine busy; suspends and clears detection |
| ce_n | input | 1 | Active-low chip select, synchronised |
| oe_n | input | 1 | Active-low output enable, synchronised |
| we_n | input | 1 | Active-low write enable, synchronised |
| addr | input | ADDR_W | Access address |
| cmd_vld | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | Command: 0 store, 1 recall, 2 auto-save off, 3 auto-save on |

## Verification
The bench builds the block with `ADDR_W` = 17 and `OE_CLOCKS` = 1. With these values both access styles and the ignored top address bit can be exercised on one instance. Every command code is swept against both values of bit 16 and both access styles. The bench injects a write and a stray read at each of the six step positions, and restarts the run from each depth of partial prefix. A busy window is placed mid-sequence and across a whole sequence. Expected pulses follow directly from the fixed address tables held in the bench.

// File: rtl/seqcmd_pkg.sv
`timescale 1ns/1ps
package seqcmd_pkg;
   localparam int KEY_W      = 16;
   localparam int PREFIX_LEN = 5;
   localparam int N_CMD      = 4;
   localparam int CODE_W     = 2;

   typedef enum logic [CODE_W-1:0] {
      CMD_STORE    = 2'd0,
      CMD_RECALL   = 2'd1,
      CMD_AUTO_OFF = 2'd2,
      CMD_AUTO_ON  = 2'd3
   } seq_cmd_e;

   // ordered unlock prefix
   function automatic logic [KEY_W-1:0] prefix_key(input int idx);
      case (idx)
         0:       return 16'h4E38;
         1:       return 16'hB1C7;
         2:       return 16'h83E0;
         3:       return 16'h7C1F;
         4:       return 16'h703F;
         default: return 16'h0000;
      endcase
   endfunction

   // sixth address per command code
   function automatic logic [KEY_W-1:0] cmd_key(input int idx);
      case (idx)
         0:       return 16'h8FC0;
         1:       return 16'h4C63;
         2:       return 16'h8B45;
         3:       return 16'h4B46;
         default: return 16'h0000;
      endcase
   endfunction
endpackage

// File: rtl/seqcmd_edge.sv
`timescale 1ns/1ps
module seqcmd_edge #(
   parameter bit OE_CLOCKS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic acc_stb,
   output logic acc_wr
);
   logic ce_q;
   logic ce_fall;
   logic oe_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) ce_q <= 1'b1;
      else        ce_q <= ce_n;
   end

   assign ce_fall = ce_q & ~ce_n;

   generate
      if (OE_CLOCKS) begin : g_oe
         logic oe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) oe_q <= 1'b1;
            else        oe_q <= oe_n;
         end
         assign oe_fall = oe_q & ~oe_n & ~ce_n;
      end else begin : g_ce_only
         logic unused_oe;
         assign unused_oe = oe_n;
         assign oe_fall   = 1'b0;
      end
   endgenerate

   assign acc_stb = ce_fall | oe_fall;
   assign acc_wr  = ~we_n;
endmodule

// File: rtl/seqcmd_match.sv
`timescale 1ns/1ps
module seqcmd_match
   import seqcmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              acc_stb,
   input  logic              acc_wr,
   input  logic [KEY_W-1:0]  key,
   output logic              cmd_vld,
   output logic [CODE_W-1:0] cmd_code
);
   localparam int STEP_W = $clog2(PREFIX_LEN + 1);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

   generate
      if ((1 << CODE_W) < N_CMD) begin : g_bad_code
         $error("command code too narrow for command count");
      end
   endgenerate

   logic [STEP_W-1:0] step;
   logic [N_CMD-1:0]  hit;
   logic [CODE_W-1:0] enc;
   logic [KEY_W-1:0]  want;
   logic              first_hit;
   logic [STEP_W-1:0] fallback;

   generate
      for (genvar i = 0; i < N_CMD; i++) begin : g_cmd
         assign hit[i] = (key == cmd_key(i));
      end
   endgenerate

   always_comb begin
      enc = '0;
      for (int i = 0; i < N_CMD; i++) begin
         if (hit[i]) enc = CODE_W'(i);
      end
   end

   always_comb want = prefix_key(int'(step));
   assign first_hit = (key == prefix_key(0));
   assign fallback  = first_hit ? STEP_W'(1) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step     <= '0;
         cmd_vld  <= 1'b0;
         cmd_code <= '0;
      end else begin
         cmd_vld <= 1'b0;
         if (busy) begin
            step <= '0;
         end else if (acc_stb) begin
            if (acc_wr) begin
               step <= '0;
            end else if (step == LAST_STEP) begin
               if (|hit) begin
                  cmd_vld  <= 1'b1;
                  cmd_code <= enc;
                  step     <= '0;
               end else begin
                  step <= fallback;
               end
            end else if (key == want) begin
               step <= step + STEP_W'(1);
            end else begin
               step <= fallback;
            end
         end
      end
   end
endmodule

// File: rtl/seqcmd_detect.sv
`timescale 1ns/1ps
module seqcmd_detect #(
   parameter int ADDR_W    = 17,
   parameter bit OE_CLOCKS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              cmd_vld,
   output logic [1:0]        cmd_code
);
   import seqcmd_pkg::*;

   generate
      if (ADDR_W < KEY_W) begin : g_bad_width
         $error("address narrower than compare key");
      end
      if (ADDR_W > KEY_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:KEY_W];
      end
   endgenerate

   logic acc_stb;
   logic acc_wr;

   seqcmd_edge #(.OE_CLOCKS(OE_CLOCKS)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .we_n    (we_n),
      .acc_stb (acc_stb),
      .acc_wr  (acc_wr)
   );

   seqcmd_match u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .acc_stb  (acc_stb),
      .acc_wr   (acc_wr),
      .key      (addr[KEY_W-1:0]),
      .cmd_vld  (cmd_vld),
      .cmd_code (cmd_code)
   );
endmodule

// File: rtl/seqcmd_detect_chk.sv
`timescale 1ns/1ps
module seqcmd_detect_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              ce_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              cmd_vld,
   input logic [1:0]        cmd_code
);
   // R4
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> !cmd_vld);

   // R10
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !cmd_vld);

   // R6
   read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> $past(we_n));

   // R9
   ce_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> !$past(ce_n));

   // R3
   code_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> ($past(addr[15:0]) == seqcmd_pkg::cmd_key(int'(cmd_code))));
endmodule

bind seqcmd_detect seqcmd_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .ce_n     (ce_n),
   .we_n     (we_n),
   .addr     (addr),
   .cmd_vld  (cmd_vld),
   .cmd_code (cmd_code)
);

// File: tb/seqcmd_detect_bench.sv
`timescale 1ns/1ps
module seqcmd_detect_bench;
   logic        clk = 1'b0;
   logic        rst_n, busy, ce_n, oe_n, we_n;
   logic [16:0] addr;
   logic        cmd_vld;
   logic [1:0]  cmd_code;
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   localparam logic [15:0] PFX [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
   localparam logic [15:0] CMD [4] = '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};

   always #2 clk = ~clk;

   seqcmd_detect #(.ADDR_W(17), .OE_CLOCKS(1'b1)) u_seqcmd_detect (
      .clk(clk), .rst_n(rst_n), .busy(busy), .ce_n(ce_n), .oe_n(oe_n),
      .we_n(we_n), .addr(addr), .cmd_vld(cmd_vld), .cmd_code(cmd_code));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // mode 0: ce pulse, 1: ce falls and stays low, 2: oe pulse
   task automatic acc(input logic [16:0] a, input bit wr, input int mode,
                      input bit exp_v, input int exp_c, input string req);
      @(negedge clk);
      addr = a; we_n = ~wr;
      if (mode == 2) oe_n = 1'b0; else ce_n = 1'b0;
      @(negedge clk);
      check(req, int'(cmd_vld), int'(exp_v));
      if (exp_v) check(req, int'(cmd_code), exp_c);
      if (mode == 2) oe_n = 1'b1; else if (mode == 0) ce_n = 1'b1;
      we_n = 1'b1;
      @(negedge clk);
      check("R4", int'(cmd_vld), 0);
   endtask

   task automatic pfx(input int n, input bit b16, input string req);
      for (int i = 0; i < n; i++) acc({b16, PFX[i]}, 1'b0, 0, 1'b0, 0, req);
   endtask

   task automatic full(input logic [15:0] last, input bit b16, input bit use_oe,
                       input bit exp_v, input int exp_c, input string req);
      for (int i = 0; i < 5; i++)
         acc({b16, PFX[i]}, 1'b0, use_oe ? ((i == 0) ? 1 : 2) : 0, 1'b0, 0, req);
      acc({b16, last}, 1'b0, use_oe ? 2 : 0, exp_v, exp_c, req);
      if (use_oe) begin
         @(negedge clk); ce_n = 1'b1;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; busy = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0;
      repeat (3) @(negedge clk);
      check("R1", int'(cmd_vld), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", int'(cmd_vld), 0);
      // R1: a lone last address after reset must not fire
      acc({1'b0, CMD[0]}, 1'b0, 0, 1'b0, 0, "R1");

      // R2 R3 R5 R9: every code, both bit16 values, both access styles
      for (int c = 0; c < 4; c++)
         for (int b = 0; b < 2; b++)
            for (int m = 0; m < 2; m++)
               full(CMD[c], b[0], m[0], 1'b1, c, (c == 0) ? "R2" : "R3");

      // R6: write at each step position
      for (int p = 0; p < 6; p++) begin
         pfx(p, 1'b0, "R6");
         acc({1'b0, (p < 5) ? PFX[p] : CMD[0]}, 1'b1, 0, 1'b0, 0, "R6");
         for (int k = p + 1; k < 6; k++)
            acc({1'b0, (k < 5) ? PFX[k] : CMD[0]}, 1'b0, 0, 1'b0, 0, "R6");
      end

      // R7: stray read at each step position
      for (int p = 0; p < 6; p++) begin
         pfx(p, 1'b1, "R7");
         acc({1'b1, 16'h1234}, 1'b0, 0, 1'b0, 0, "R7");
         for (int k = p + 1; k < 6; k++)
            acc({1'b1, (k < 5) ? PFX[k] : CMD[1]}, 1'b0, 0, 1'b0, 0, "R7");
      end

      // R7: restart from every partial depth (depth 5 exercises R8 restart)
      for (int p = 1; p < 6; p++) begin
         pfx(p, 1'b0, "R7");
         full(CMD[1], 1'b0, 1'b0, 1'b1, 1, "R7");
      end

      // R8: unknown sixth address is silent, next run is clean
      full(16'hFFFF, 1'b0, 1'b0, 1'b0, 0, "R8");
      full(CMD[0], 1'b0, 1'b0, 1'b1, 0, "R8");

      // R9: oe edge with ce high is not an access
      pfx(2, 1'b0, "R9");
      acc(17'h00000, 1'b0, 2, 1'b0, 0, "R9");
      for (int k = 2; k < 5; k++) acc({1'b0, PFX[k]}, 1'b0, 0, 1'b0, 0, "R9");
      acc({1'b0, CMD[3]}, 1'b0, 0, 1'b1, 3, "R9");

      // R10: busy mid-sequence clears progress
      pfx(3, 1'b0, "R10");
      @(negedge clk); busy = 1'b1;
      repeat (2) @(negedge clk);
      busy = 1'b0;
      acc({1'b0, PFX[3]}, 1'b0, 0, 1'b0, 0, "R10");
      acc({1'b0, PFX[4]}, 1'b0, 0, 1'b0, 0, "R10");
      acc({1'b0, CMD[0]}, 1'b0, 0, 1'b0, 0, "R10");
      // R10: whole sequence during busy
      @(negedge clk); busy = 1'b1;
      full(CMD[2], 1'b0, 1'b0, 1'b0, 0, "R10");
      @(negedge clk); busy = 1'b0;
      full(CMD[2], 1'b0, 1'b0, 1'b1, 2, "R10");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule